// File: doc/BRIEF.md
# Snoop Address Strobe Qualifier

This block decides, on every rising clock edge, whether an external snoop address strobe is accepted. A strobe is accepted only while one of three hold mechanisms keeps the processor off the bus. These are an address-hold request, an acknowledged bus hold, and a forced back-off. Each mechanism also has to have been active long enough for its own settling time. An accepted strobe produces a one-clock snoop-start pulse and captures the invalidate input taken at the same edge. The cache uses that pulse to begin a tag lookup.

Several conditions block acceptance even inside a valid hold window. A strobe is refused while the cache reports a modified hit. It is refused on the edge right after the processor drove its own address strobe. It is also refused on the edge right after a previously accepted snoop, so accepted snoops are at least two clocks apart. After an acceptance, the hold mechanism that made the strobe valid must still be active one edge later. If it is not, a violation flag pulses for one clock.

Top module: `snoop_qual`

## Requirements
- R1: After reset, `snp_start`, `snp_inv_q` and `hold_viol` are all 0.
- R2: A strobe (`snp_stb_n` = 0 at an edge) with none of `addr_hold`, `hold_ack` or `back_off` high at that edge is not accepted.
- R3: Under `addr_hold`, a strobe is accepted only if `addr_hold` has been high at that edge and at the AHOLD_DLY (default 2) edges before it. With the default, the strobe counts from the second edge after the first edge at which `addr_hold` is seen high.
- R4: Under `hold_ack`, a strobe is accepted only if `hold_ack` has been high at that edge and at the HOLD_DLY (default 1) edges before it.
- R5: Under `back_off`, a strobe is accepted only if `back_off` has been high at that edge and at the BOFF_DLY (default 2) edges before it.
- R6: A strobe is not accepted at an edge where `mod_hit` is high.
- R7: A strobe is not accepted at the edge that follows an edge where `cpu_ads` was high. A strobe at the same edge as `cpu_ads` is not blocked.
- R8: A strobe is not accepted at the edge right after an accepted strobe, so accepted snoops are at least two edges apart.
- R9: An accepted strobe raises `snp_start` for exactly one clock, starting just after the accepting edge.
- R10: `snp_inv_q` takes the value of `snp_inv` at each accepting edge and holds it until the next accepting edge.
- R11: If none of the hold mechanisms that qualified an accepted strobe is still high at the following edge, `hold_viol` is 1 for the clock after that edge. Otherwise it stays 0.
- R12: A hold mechanism that drops restarts its settling count. A new episode of it again needs its full delay before a strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| snp_stb_n | input | 1 | External snoop address strobe, active low |
| snp_inv | input | 1 | Invalidate request accompanying the strobe |
| addr_hold | input | 1 | Address-hold request, active high |
| hold_ack | input | 1 | Bus hold acknowledged, active high |
| back_off | input | 1 | Forced back-off, active high |
| cpu_ads | input | 1 | Processor's own address strobe, active high |
| mod_hit | input | 1 | Cache reports a modified hit, active high |
| snp_start | output | 1 | One-clock pulse: snoop accepted |
| snp_inv_q | output | 1 | Invalidate value captured with the last accepted snoop |
| hold_viol | output | 1 | One-clock pulse: qualifying hold dropped too early |

## Verification
Every output is registered. `snp_start` and `snp_inv_q` reflect the edge at which the strobe is sampled. `hold_viol` reflects the edge one after the accepting edge. The bench drives inputs on the falling edge and reads outputs one time step after the next rising edge. Each check therefore compares against the edge it names, with no extra latency to count. The delay sweep places a strobe 0 to 4 edges after each trigger first goes high. The expected acceptance comes from comparing that offset with the trigger's delay.

// File: rtl/snq_pkg.sv
package snq_pkg;
   localparam int unsigned NUM_TRG = 3;
   localparam int unsigned TRG_AHOLD = 0;
   localparam int unsigned TRG_HOLD  = 1;
   localparam int unsigned TRG_BOFF  = 2;

   function automatic int unsigned trg_dly(input int unsigned idx,
                                           input int unsigned d_ahold,
                                           input int unsigned d_hold,
                                           input int unsigned d_boff);
      if (idx == TRG_AHOLD) return d_ahold;
      if (idx == TRG_HOLD)  return d_hold;
      return d_boff;
   endfunction

   function automatic int unsigned max3(input int unsigned a, b, c);
      int unsigned m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction
endpackage

// File: rtl/snq_trig_window.sv
module snq_trig_window #(
   parameter int unsigned DLY = 2,
   parameter int unsigned CW  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic elig
);
   localparam logic [CW-1:0] SAT = CW'(DLY);

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_cnt <= '0;
      else if (!trig)
         run_cnt <= '0;
      else if (run_cnt < SAT)
         run_cnt <= run_cnt + 1'b1;
   end

   generate
      if (DLY == 0) begin : g_nodly
         assign elig = trig;
      end else begin : g_dly
         assign elig = trig && (run_cnt >= SAT);
      end
   endgenerate

   // R12
   rise_not_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (DLY > 0) && $rose(trig) |-> !elig);
   // R2
   elig_needs_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      elig |-> trig);
endmodule

// File: rtl/snq_gate.sv
module snq_gate #(
   parameter int unsigned NT = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          snp_stb_n,
   input  logic          mod_hit,
   input  logic          cpu_ads,
   input  logic [NT-1:0] elig_vec,
   output logic          accept,
   output logic          acc_q
);
   logic ads_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ads_q <= 1'b0;
         acc_q <= 1'b0;
      end else begin
         ads_q <= cpu_ads;
         acc_q <= accept;
      end
   end

   always_comb begin
      accept = !snp_stb_n && (|elig_vec) && !mod_hit && !ads_q && !acc_q;
   end

   // R8
   spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q |-> !accept);
   // R6
   modhit_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mod_hit |-> !accept);
endmodule

// File: rtl/snq_viol_mon.sv
module snq_viol_mon #(
   parameter int unsigned NT = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          acc_q,
   input  logic [NT-1:0] elig_vec,
   input  logic [NT-1:0] trig_vec,
   output logic          viol
);
   logic [NT-1:0] armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= '0;
         viol  <= 1'b0;
      end else begin
         armed <= accept ? elig_vec : '0;
         viol  <= (|armed) && !(|(armed & trig_vec));
      end
   end

   // R11
   viol_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol |-> $past(acc_q));
   // R11
   viol_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol |=> !viol);
endmodule

// File: rtl/snoop_qual.sv
module snoop_qual #(
   parameter int unsigned AHOLD_DLY = 2,
   parameter int unsigned HOLD_DLY  = 1,
   parameter int unsigned BOFF_DLY  = 2,
   parameter bit          VIOL_EN   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic snp_stb_n,
   input  logic snp_inv,
   input  logic addr_hold,
   input  logic hold_ack,
   input  logic back_off,
   input  logic cpu_ads,
   input  logic mod_hit,
   output logic snp_start,
   output logic snp_inv_q,
   output logic hold_viol
);
   import snq_pkg::*;

   localparam int unsigned MAXD = max3(AHOLD_DLY, HOLD_DLY, BOFF_DLY);
   localparam int unsigned CW   = $clog2(MAXD + 2);

   initial begin
      dly_range_chk: assert (MAXD <= 15)
         else $error("snoop_qual: settling delay above 15");
   end

   logic [NUM_TRG-1:0] trig_vec;
   logic [NUM_TRG-1:0] elig_vec;
   logic               accept;
   logic               acc_q;
   logic               inv_q;

   assign trig_vec[TRG_AHOLD] = addr_hold;
   assign trig_vec[TRG_HOLD]  = hold_ack;
   assign trig_vec[TRG_BOFF]  = back_off;

   for (genvar g = 0; g < NUM_TRG; g++) begin : g_win
      snq_trig_window #(
         .DLY(trg_dly(g, AHOLD_DLY, HOLD_DLY, BOFF_DLY)),
         .CW (CW)
      ) u_win (
         .clk  (clk),
         .rst_n(rst_n),
         .trig (trig_vec[g]),
         .elig (elig_vec[g])
      );
   end

   snq_gate #(.NT(NUM_TRG)) u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .snp_stb_n(snp_stb_n),
      .mod_hit  (mod_hit),
      .cpu_ads  (cpu_ads),
      .elig_vec (elig_vec),
      .accept   (accept),
      .acc_q    (acc_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         inv_q <= 1'b0;
      else if (accept)
         inv_q <= snp_inv;
   end

   generate
      if (VIOL_EN) begin : g_viol
         snq_viol_mon #(.NT(NUM_TRG)) u_viol (
            .clk     (clk),
            .rst_n   (rst_n),
            .accept  (accept),
            .acc_q   (acc_q),
            .elig_vec(elig_vec),
            .trig_vec(trig_vec),
            .viol    (hold_viol)
         );
      end else begin : g_noviol
         assign hold_viol = 1'b0;
      end
   endgenerate

   assign snp_start = acc_q;
   assign snp_inv_q = inv_q;

   // R9
   start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_start |=> !snp_start);
   // R2
   start_needs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_start |-> $past(addr_hold || hold_ack || back_off));
   // R10
   inv_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_start |-> snp_inv_q == $past(snp_inv));
   // R7
   ads_blackout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cpu_ads) |-> !accept);
   // R10
   inv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !snp_start |-> $stable(snp_inv_q));
endmodule

// File: tb/snoop_qual_tb.sv
module snoop_qual_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic snp_stb_n = 1'b1, snp_inv = 1'b0;
   logic addr_hold = 1'b0, hold_ack = 1'b0, back_off = 1'b0;
   logic cpu_ads = 1'b0, mod_hit = 1'b0;
   logic snp_start, snp_inv_q, hold_viol;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   snoop_qual u_dut (
      .clk(clk), .rst_n(rst_n), .snp_stb_n(snp_stb_n), .snp_inv(snp_inv),
      .addr_hold(addr_hold), .hold_ack(hold_ack), .back_off(back_off),
      .cpu_ads(cpu_ads), .mod_hit(mod_hit),
      .snp_start(snp_start), .snp_inv_q(snp_inv_q), .hold_viol(hold_viol)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // one edge: trig = {boff, hold, ahold}
   task automatic cyc(input logic stb, input logic inv, input logic [2:0] trig,
                      input logic ads, input logic mh);
      @(negedge clk);
      snp_stb_n = ~stb; snp_inv = inv;
      addr_hold = trig[0]; hold_ack = trig[1]; back_off = trig[2];
      cpu_ads = ads; mod_hit = mh;
      @(posedge clk);
      #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 3'b000, 1'b0, 1'b0);
   endtask

   initial begin
      int dly [3];
      dly[0] = 2; dly[1] = 1; dly[2] = 2;
      #12;
      // R1
      chk("R1 start", snp_start, 1'b0);
      chk("R1 inv", snp_inv_q, 1'b0);
      chk("R1 viol", hold_viol, 1'b0);
      rst_n = 1'b1;
      idle(2);

      // R2: strobe with no hold
      cyc(1'b1, 1'b1, 3'b000, 1'b0, 1'b0);
      chk("R2", snp_start, 1'b0);
      idle(2);

      // R3/R4/R5/R12: delay sweep per trigger
      for (int t = 0; t < 3; t++) begin
         for (int d = 0; d <= 4; d++) begin
            logic [2:0] tv;
            tv = 3'b001 << t;
            for (int k = 0; k < d; k++) cyc(1'b0, 1'b0, tv, 1'b0, 1'b0);
            cyc(1'b1, 1'b0, tv, 1'b0, 1'b0);
            if (t == 0) chk("R3 ahold window", snp_start, 1'(d >= dly[t]));
            else if (t == 1) chk("R4 hold window", snp_start, 1'(d >= dly[t]));
            else chk("R5 boff window", snp_start, 1'(d >= dly[t]));
            cyc(1'b0, 1'b0, tv, 1'b0, 1'b0);
            chk("R9 one pulse", snp_start, 1'b0);
            chk("R11 no viol", hold_viol, 1'b0);
            idle(1);
         end
      end

      // R12: drop and re-raise restarts count
      cyc(1'b0, 1'b0, 3'b001, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 3'b001, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 3'b000, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 3'b001, 1'b0, 1'b0);
      chk("R12 restart", snp_start, 1'b0);
      idle(2);

      // R6: modified hit blocks
      cyc(1'b0, 1'b0, 3'b010, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 3'b010, 1'b0, 1'b1);
      chk("R6 modhit", snp_start, 1'b0);
      cyc(1'b1, 1'b0, 3'b010, 1'b0, 1'b0);
      chk("R6 after modhit", snp_start, 1'b1);
      cyc(1'b0, 1'b0, 3'b010, 1'b0, 1'b0);

      // R7: own address strobe blackout
      cyc(1'b1, 1'b0, 3'b010, 1'b1, 1'b0);
      chk("R7 same edge", snp_start, 1'b1);
      cyc(1'b0, 1'b0, 3'b010, 1'b1, 1'b0);
      cyc(1'b1, 1'b0, 3'b010, 1'b0, 1'b0);
      chk("R7 edge after ads", snp_start, 1'b0);
      cyc(1'b1, 1'b0, 3'b010, 1'b0, 1'b0);
      chk("R7 two after ads", snp_start, 1'b1);

      // R8: spacing
      cyc(1'b1, 1'b0, 3'b010, 1'b0, 1'b0);
      chk("R8 back to back", snp_start, 1'b0);
      cyc(1'b1, 1'b0, 3'b010, 1'b0, 1'b0);
      chk("R8 every other", snp_start, 1'b1);
      cyc(1'b0, 1'b0, 3'b010, 1'b0, 1'b0);

      // R10: invalidate capture and hold
      cyc(1'b1, 1'b1, 3'b010, 1'b0, 1'b0);
      chk("R10 capture 1", snp_inv_q, 1'b1);
      cyc(1'b0, 1'b0, 3'b010, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 3'b010, 1'b0, 1'b1);
      chk("R10 hold on reject", snp_inv_q, 1'b1);
      cyc(1'b1, 1'b0, 3'b010, 1'b0, 1'b0);
      chk("R10 capture 0", snp_inv_q, 1'b0);

      // R11: qualifying hold drops right after accept
      cyc(1'b0, 1'b0, 3'b010, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 3'b010, 1'b0, 1'b0);
      chk("R11 accept", snp_start, 1'b1);
      cyc(1'b0, 1'b0, 3'b000, 1'b0, 1'b0);
      chk("R11 viol", hold_viol, 1'b1);
      cyc(1'b0, 1'b0, 3'b000, 1'b0, 1'b0);
      chk("R11 viol pulse", hold_viol, 1'b0);

      // R11: a non-qualifying hold does not cover
      idle(1);
      cyc(1'b0, 1'b0, 3'b001, 1'b0, 1'b0);
      cyc(1'b0, 1'b0, 3'b001, 1'b0, 1'b0);
      cyc(1'b1, 1'b0, 3'b001, 1'b0, 1'b0);
      chk("R3 accept", snp_start, 1'b1);
      cyc(1'b0, 1'b0, 3'b100, 1'b0, 1'b0);
      chk("R11 other trigger", hold_viol, 1'b1);
      idle(2);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule